// File: doc/BRIEF.md
# Triplex LCD Segment Driver

This block drives a three-row multiplexed liquid crystal panel of 36 segments: 3 common rows by 12 segment lines. A host loads a 36-bit segment map through a slow three-wire serial port made of an active-low select, a data line and a shift clock. The block keeps the map in a display latch and refreshes the panel on its own. The host never has to repeat a load.

All logic runs from a free-running oscillator clock. The serial pins are brought into that domain through synchronisers and edge detectors. A frame counter steps through six equal phases. In the first three phases each row is scanned with positive polarity, and in the last three with negative polarity. This keeps the average voltage across every pixel at zero. Every backplane and segment output is a 2-bit code that selects one of four analog levels in an external buffer: 0 = ground, 1 = one third, 2 = two thirds, 3 = full supply. A serial output presents the bit that falls off the end of the shift register. This lets a second device be chained behind the first.

Top module: `lcd_triplex_drv`

## Requirements
- R1: While reset is held, and at the first cycle after release, the outputs are as follows. Backplane A shows code 3 and backplanes B and C show code 1. Every segment shows code 2, and `ser_out` is 0. The display latch and the shift register both reset to all zeros.
- R2: The frame consists of six phases of `PHASE_LEN` (32) clock cycles each, in the fixed order A+, B+, C+, A-, B-, C-. The frame then repeats with a period of 192 cycles. Phase 0 begins at the first clock edge after reset is released.
- R3: In a positive phase, the scanned backplane shows code 3 and the other backplanes show code 1. In a negative phase, the scanned backplane shows code 0 and the other backplanes show code 2. Backplane k occupies `bp_lvl[2k+1:2k]`, with A = 0, B = 1 and C = 2.
- R4: While row r is scanned, segment s follows latch bit `r*12+s`. A set bit (segment on) gives code 0 in a positive phase and code 3 in a negative phase. A clear bit gives code 2 in a positive phase and code 1 in a negative phase. Segment s occupies `seg_lvl[2s+1:2s]`.
- R5: While `cs_n` is low, each rising edge of `ser_clk` shifts `ser_in` into the shift register MSB first. After 36 edges, the first bit sent occupies latch bit 35.
- R6: Edges on `ser_clk` while `cs_n` is high leave the shift register unchanged.
- R7: The shift register is copied into the display latch only on the rising edge of `cs_n`. A load that is still in progress does not change the outputs, and the latched map persists across any number of frames.
- R8: `ser_out` is the most significant bit of the shift register. It therefore presents the bit that was shifted in 36 `ser_clk` edges earlier, which feeds a chained device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low; its rising edge latches the map |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_in | input | 1 | Serial data, MSB first |
| ser_out | output | 1 | Shift register MSB, for chaining |
| bp_lvl | output | 6 | Level codes of backplanes A, B, C (2 bits each) |
| seg_lvl | output | 24 | Level codes of the 12 segment lines (2 bits each) |

## Verification
The bench builds the block with its default parameters: 3 rows, 12 segment lines and 32-cycle phases. With these values a full 192-cycle frame takes only a few hundred clocks. This makes it practical to check every phase, including the boundaries at cycles 31/32, 95/96 and 191/0, for each loaded pattern. Running 36-bit words through the 3-flop synchronisers lets the bench test several things: the MSB-first bit placement, a partial load that must stay invisible, stray shift clocks with the select deasserted, and a 72-edge chained shift observed on `ser_out`.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    // Drive-level codes understood by the external analog buffers.
    typedef enum logic [1:0] {
        LVL_GND  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_FULL = 2'd3
    } lvl_e;
endpackage

// File: rtl/lcd_serial_in.sv
module lcd_serial_in #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         ser_clk,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] map_o
);
    typedef struct packed {
        logic [2:0]   sk;
        logic [1:0]   di;
        logic [2:0]   cs;
        logic [W-1:0] sh;
        logic [W-1:0] lat;
    } st_t;

    st_t st_d, st_q;
    logic sk_rise, cs_act, cs_rise;

    always_comb begin
        st_d    = st_q;
        sk_rise = st_q.sk[1] & ~st_q.sk[2];
        cs_act  = ~st_q.cs[1];
        cs_rise = st_q.cs[1] & ~st_q.cs[2];
        st_d.sk = {st_q.sk[1:0], ser_clk};
        st_d.di = {st_q.di[0], ser_in};
        st_d.cs = {st_q.cs[1:0], cs_n};
        if (sk_rise && cs_act) begin
            st_d.sh = {st_q.sh[W-2:0], st_q.di[1]};
        end
        if (cs_rise) begin
            st_d.lat = st_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cs  <= 3'b111;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.sh[W-1];
    assign map_o   = st_q.lat;

    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> $stable(st_q.sh)); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(st_q.lat)); // R7
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
    parameter int N_COM     = 3,
    parameter int PHASE_LEN = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    output logic [(N_COM > 1 ? $clog2(N_COM) : 1)-1:0] row_o,
    output logic                                   neg_o
);
    localparam int RW = (N_COM > 1) ? $clog2(N_COM) : 1;
    localparam int CW = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [RW-1:0] row;
        logic          neg;
    } st_t;

    st_t st_d, st_q;
    logic last_cyc;

    always_comb begin
        st_d     = st_q;
        last_cyc = (st_q.cyc == CW'(PHASE_LEN - 1));
        if (last_cyc) begin
            st_d.cyc = '0;
            if (st_q.row == RW'(N_COM - 1)) begin
                st_d.row = '0;
                st_d.neg = ~st_q.neg;
            end else begin
                st_d.row = st_q.row + 1'b1;
            end
        end else begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_o = st_q.row;
    assign neg_o = st_q.neg;

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row < RW'(N_COM)); // R2
    AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cyc |=> ($stable(st_q.row) && $stable(st_q.neg))); // R2
endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
    import lcd_pkg::*;
#(
    parameter int N_COM = 3,
    parameter int N_SEG = 12,
    parameter int RW    = 2
) (
    input  logic [RW-1:0]          row_i,
    input  logic                   neg_i,
    input  logic [N_COM*N_SEG-1:0] map_i,
    output logic [2*N_COM-1:0]     bp_o,
    output logic [2*N_SEG-1:0]     seg_o
);
    logic [N_SEG-1:0] row_bits;

    always_comb begin
        row_bits = '0;
        for (int c = 0; c < N_COM; c++) begin
            if (row_i == RW'(c)) row_bits = map_i[c*N_SEG +: N_SEG];
        end
    end

    for (genvar k = 0; k < N_COM; k++) begin : g_bp
        always_comb begin
            if (row_i == RW'(k)) bp_o[2*k +: 2] = neg_i ? LVL_GND  : LVL_FULL;
            else                 bp_o[2*k +: 2] = neg_i ? LVL_HIGH : LVL_LOW;
        end
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        always_comb begin
            if (row_bits[s]) seg_o[2*s +: 2] = neg_i ? LVL_FULL : LVL_GND;
            else             seg_o[2*s +: 2] = neg_i ? LVL_LOW  : LVL_HIGH;
        end
    end
endmodule

// File: rtl/lcd_triplex_drv.sv
module lcd_triplex_drv
    import lcd_pkg::*;
#(
    parameter int N_COM     = 3,
    parameter int N_SEG     = 12,
    parameter int PHASE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ser_clk,
    input  logic                 ser_in,
    output logic                 ser_out,
    output logic [2*N_COM-1:0]   bp_lvl,
    output logic [2*N_SEG-1:0]   seg_lvl
);
    localparam int W  = N_COM * N_SEG;
    localparam int RW = (N_COM > 1) ? $clog2(N_COM) : 1;

    logic [W-1:0]  map;
    logic [RW-1:0] row;
    logic          neg;

    lcd_serial_in #(.W(W)) i_ser (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ser_clk(ser_clk),
        .ser_in(ser_in), .ser_out(ser_out), .map_o(map)
    );

    lcd_frame_timer #(.N_COM(N_COM), .PHASE_LEN(PHASE_LEN)) i_tmr (
        .clk(clk), .rst_n(rst_n), .row_o(row), .neg_o(neg)
    );

    lcd_wave_gen #(.N_COM(N_COM), .N_SEG(N_SEG), .RW(RW)) i_wav (
        .row_i(row), .neg_i(neg), .map_i(map), .bp_o(bp_lvl), .seg_o(seg_lvl)
    );

    // Checker views: which backplanes sit at a rail, and segment polarity bits.
    logic [N_COM-1:0] bp_rail;
    logic [N_COM-1:0] bp_mid_ok;
    logic [N_SEG-1:0] seg_lsb;
    always_comb begin
        for (int k = 0; k < N_COM; k++) begin
            bp_rail[k]   = (bp_lvl[2*k +: 2] == LVL_GND) || (bp_lvl[2*k +: 2] == LVL_FULL);
            bp_mid_ok[k] = bp_rail[k] ||
                           (bp_lvl[2*k +: 2] == (neg ? LVL_HIGH : LVL_LOW));
        end
        for (int s = 0; s < N_SEG; s++) seg_lsb[s] = seg_lvl[2*s];
    end

    AST_ONE_RAIL_BP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(bp_rail)); // R3
    AST_BP_MID_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        &bp_mid_ok); // R3
    AST_SEG_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (neg ? (&seg_lsb) : !(|seg_lsb))); // R4
    AST_POLARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(neg) |-> $changed(seg_lsb[0])); // R4
endmodule

// File: tb/test_lcd_triplex_drv.sv
module test_lcd_triplex_drv;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 192;
    localparam int NPAT       = 6;
    localparam logic [35:0] PATS [NPAT] = '{
        36'h000000000, 36'hFFFFFFFFF, 36'h000000FFF,
        36'hFFF000000, 36'h5A5C3C81E, 36'h123456789
    };

    logic clk = 0, rst_n = 0, cs_n = 1, ser_clk = 0, ser_in = 0;
    logic ser_out;
    logic [5:0]  bp_lvl;
    logic [23:0] seg_lvl;
    int nchk = 0, nfail = 0, tcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) begin
        if (!rst_n) tcnt <= 0;
        else        tcnt <= tcnt + 1;
    end

    lcd_triplex_drv i_lcd_triplex_drv (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ser_clk(ser_clk),
        .ser_in(ser_in), .ser_out(ser_out), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [5:0] exp_bp(int p);
        logic [5:0] v;
        for (int k = 0; k < 3; k++) begin
            if (p % 3 == k) v[2*k +: 2] = (p >= 3) ? 2'd0 : 2'd3;
            else            v[2*k +: 2] = (p >= 3) ? 2'd2 : 2'd1;
        end
        return v;
    endfunction

    function automatic logic [23:0] exp_seg(logic [35:0] w, int p);
        logic [23:0] v;
        for (int s = 0; s < 12; s++) begin
            if (w[(p % 3)*12 + s]) v[2*s +: 2] = (p >= 3) ? 2'd3 : 2'd0;
            else                   v[2*s +: 2] = (p >= 3) ? 2'd1 : 2'd2;
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Wait for frame position pos, then compare all drive outputs.
    task automatic check_at(input logic [35:0] w, input int pos, input string req);
        int p;
        do @(negedge clk); while ((tcnt % FRAME) != pos);
        p = pos / 32;
        check({bp_lvl, seg_lvl} == {exp_bp(p), exp_seg(w, p)}, req,
              {34'd0, bp_lvl, seg_lvl}, {34'd0, exp_bp(p), exp_seg(w, p)});
    endtask

    task automatic check_frame(input logic [35:0] w, input string req);
        for (int p = 0; p < 6; p++) check_at(w, p*32 + 16, req);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_in = b;
        repeat (4) @(negedge clk);
        ser_clk = 1;
        repeat (4) @(negedge clk);
        ser_clk = 0;
    endtask

    task automatic send_word(input logic [35:0] w);
        for (int i = 35; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic load(input logic [35:0] w);
        @(negedge clk) cs_n = 0;
        repeat (4) @(negedge clk);
        send_word(w);
        repeat (2) @(negedge clk);
        cs_n = 1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [35:0] nw, mw;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({bp_lvl, seg_lvl, ser_out} == {6'b010111, {12{2'b10}}, 1'b0}, "R1",
              {33'd0, bp_lvl, seg_lvl, ser_out}, {33'd0, 6'b010111, {12{2'b10}}, 1'b0});
        rst_n = 1;
        check_at(36'h0, 1, "R1");
        // R2: phase boundaries with an empty map
        check_at(36'h0, 31, "R2");
        check_at(36'h0, 32, "R2");
        check_at(36'h0, 95, "R2");
        check_at(36'h0, 96, "R2");
        check_at(36'h0, 191, "R2");
        check_at(36'h0, 0, "R2");
        // R3 R4 R5: table of patterns, one full frame each
        for (int i = 0; i < NPAT; i++) begin
            load(PATS[i]);
            check_frame(PATS[i], "R3/R4/R5");
        end
        // R6: stray shift clocks with select high, then an empty select pulse
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        @(negedge clk) cs_n = 0;
        repeat (6) @(negedge clk);
        cs_n = 1;
        repeat (6) @(negedge clk);
        check_frame(PATS[NPAT-1], "R6");
        // R7: partial load stays invisible
        nw = 36'hC3A5F0961;
        mw = 36'h9E1B2D47C;
        @(negedge clk) cs_n = 0;
        repeat (4) @(negedge clk);
        for (int i = 35; i >= 16; i--) send_bit(nw[i]);
        check_frame(PATS[NPAT-1], "R7");
        for (int i = 15; i >= 0; i--) send_bit(nw[i]);
        // R8: chained shift, ser_out replays nw MSB first
        for (int i = 35; i >= 0; i--) begin
            @(negedge clk);
            check(ser_out == nw[i], "R8", {63'd0, ser_out}, {63'd0, nw[i]});
            send_bit(mw[i]);
        end
        check_at(PATS[NPAT-1], 40, "R7");
        @(negedge clk) cs_n = 1;
        repeat (6) @(negedge clk);
        check_frame(mw, "R7");
        check_frame(mw, "R7");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule